// File: doc/BRIEF.md
# Atomic memory operation ALU

This block computes both results of an atomic read-modify-write. It takes an operation code, a width select, the value just loaded from memory and the register operand. It returns the value that goes back to memory and the value that goes to the destination register. The destination always gets the original memory value. Word operations work on the low 32 bits only, and every 64-bit result they produce is sign-extended from bit 31.

Load-reserved and store-conditional are decoded and marked with their own flags, and they carry only their plain data. The reservation itself and the memory access belong to the surrounding pipeline. An unknown operation code or width is reported on a separate illegal output.

The block has one register stage. A request presented with `in_valid` high is captured on a rising clock edge, and its results appear on the outputs after that edge together with `out_valid`. The outputs hold their values until the next request.

Top module: `amo_alu`

## Requirements
- R1: During and directly after reset, `out_valid`, `lr_flag`, `sc_flag` and `illegal` are 0, and `store_data` and `dest_data` are 0.
- R2: A request sampled with `in_valid` high at a rising edge produces its results, with `out_valid` = 1, after that edge. At an edge where `in_valid` is low, `out_valid` becomes 0 and every data output and flag keeps its previous value, whatever the other inputs do.
- R3: Code 5'h00 (add) stores memory + operand, wrapping modulo 2^64 for width 3 and modulo 2^32 for width 2.
- R4: Code 5'h01 (swap) stores the operand. Codes 5'h04, 5'h08 and 5'h0c store the bitwise xor, or and and of memory and operand.
- R5: Code 5'h10 (signed min) stores the operand only if it is strictly less than memory as a two's complement number, and otherwise stores memory. Code 5'h14 (signed max) does the same for strictly greater.
- R6: Codes 5'h18 (unsigned min) and 5'h1c (unsigned max) make the same strict choice on unsigned magnitudes.
- R7: For every legal code other than 5'h03, `dest_data` is the loaded memory value. With width 2 (word), it is the low 32 bits sign-extended from bit 31.
- R8: With width 2, input bits 63:32 of both operands have no effect, and `store_data` bits 63:32 are copies of bit 31.
- R9: Code 5'h02 (load-reserved) sets `lr_flag`, returns the loaded value on `dest_data` as in R7, and drives `store_data` to 0.
- R10: Code 5'h03 (store-conditional) sets `sc_flag`, drives `store_data` to the register operand (sign-extended from bit 31 for width 2), and drives `dest_data` to 0.
- R11: Any code not listed above, or any width other than 2 (word) or 3 (doubleword), sets `illegal` with both flags 0 and both data outputs 0. At most one of `lr_flag`, `sc_flag` and `illegal` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 5 | Atomic operation code |
| width_sel | input | 2 | 2 = 32-bit word, 3 = 64-bit doubleword |
| mem_data | input | 64 | Value loaded from memory |
| reg_data | input | 64 | Register operand |
| out_valid | output | 1 | Results valid for the request of the previous edge |
| store_data | output | 64 | Value to write back to memory |
| dest_data | output | 64 | Value for the destination register |
| lr_flag | output | 1 | Request was a load-reserved |
| sc_flag | output | 1 | Request was a store-conditional |
| illegal | output | 1 | Code or width not recognised |

## Verification
The hardest case to reach from the ports is a word operation whose answer would change if the upper input bits leaked in. One example is a signed min where the low halves are negative but the full 64-bit values compare the other way. Another is an add whose 32-bit sum crosses into the sign bit. The stimulus builds these cases on purpose: it fills bits 63:32 of both operands with patterns whose sign is opposite to that of the low word. It then checks the choice, the sign extension of the result and the sign extension of the returned value against a reference written with 32-bit integer types.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int OPW = 5;

  localparam logic [OPW-1:0] OPC_ADD  = 5'h00;
  localparam logic [OPW-1:0] OPC_SWAP = 5'h01;
  localparam logic [OPW-1:0] OPC_RSV  = 5'h02;
  localparam logic [OPW-1:0] OPC_CND  = 5'h03;
  localparam logic [OPW-1:0] OPC_XOR  = 5'h04;
  localparam logic [OPW-1:0] OPC_OR   = 5'h08;
  localparam logic [OPW-1:0] OPC_AND  = 5'h0c;
  localparam logic [OPW-1:0] OPC_SMIN = 5'h10;
  localparam logic [OPW-1:0] OPC_SMAX = 5'h14;
  localparam logic [OPW-1:0] OPC_UMIN = 5'h18;
  localparam logic [OPW-1:0] OPC_UMAX = 5'h1c;

  localparam logic [1:0] WID_WORD  = 2'd2;
  localparam logic [1:0] WID_DWORD = 2'd3;

  typedef enum logic [3:0] {
    K_ADD, K_SWAP, K_XOR, K_OR, K_AND,
    K_SMIN, K_SMAX, K_UMIN, K_UMAX,
    K_RSV, K_CND, K_BAD
  } amo_kind_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic [1:0]     width_sel,
  output amo_kind_e      kind,
  output logic           is_word,
  output logic           bad_req
);

  logic width_ok;
  amo_kind_e op_kind;

  assign width_ok = (width_sel == WID_WORD) || (width_sel == WID_DWORD);
  assign is_word  = (width_sel == WID_WORD);

  always_comb begin
    unique case (op_code)
      OPC_ADD:  op_kind = K_ADD;
      OPC_SWAP: op_kind = K_SWAP;
      OPC_XOR:  op_kind = K_XOR;
      OPC_OR:   op_kind = K_OR;
      OPC_AND:  op_kind = K_AND;
      OPC_SMIN: op_kind = K_SMIN;
      OPC_SMAX: op_kind = K_SMAX;
      OPC_UMIN: op_kind = K_UMIN;
      OPC_UMAX: op_kind = K_UMAX;
      OPC_RSV:  op_kind = K_RSV;
      OPC_CND:  op_kind = K_CND;
      default:  op_kind = K_BAD;
    endcase
  end

  assign kind    = width_ok ? op_kind : K_BAD;
  assign bad_req = (kind == K_BAD);

endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  amo_kind_e        kind,
  input  logic             is_word,
  input  logic [XLEN-1:0]  mem_val,
  input  logic [XLEN-1:0]  reg_val,
  output logic [XLEN-1:0]  store_val,
  output logic [XLEN-1:0]  dest_val
);

  localparam int PAD = XLEN - WORD_W;

  // Narrow to the word and widen again, with or without the sign.
  function automatic logic [XLEN-1:0] fit_s(input logic [XLEN-1:0] v, input logic w);
    return w ? {{PAD{v[WORD_W-1]}}, v[WORD_W-1:0]} : v;
  endfunction

  function automatic logic [XLEN-1:0] fit_u(input logic [XLEN-1:0] v, input logic w);
    return w ? {{PAD{1'b0}}, v[WORD_W-1:0]} : v;
  endfunction

  // Strict choice: the operand wins only when the test is true.
  function automatic logic [XLEN-1:0] pick(input logic take_reg,
                                           input logic [XLEN-1:0] r,
                                           input logic [XLEN-1:0] m);
    return take_reg ? r : m;
  endfunction

  logic [XLEN-1:0] m_s, r_s, m_u, r_u, sum, raw;
  logic            s_lt, s_gt, u_lt, u_gt;

  assign m_s = fit_s(mem_val, is_word);
  assign r_s = fit_s(reg_val, is_word);
  assign m_u = fit_u(mem_val, is_word);
  assign r_u = fit_u(reg_val, is_word);

  assign sum  = m_s + r_s;
  assign s_lt = $signed(r_s) < $signed(m_s);
  assign s_gt = $signed(r_s) > $signed(m_s);
  assign u_lt = r_u < m_u;
  assign u_gt = r_u > m_u;

  always_comb begin
    unique case (kind)
      K_ADD:   raw = sum;
      K_SWAP:  raw = r_s;
      K_XOR:   raw = m_s ^ r_s;
      K_OR:    raw = m_s | r_s;
      K_AND:   raw = m_s & r_s;
      K_SMIN:  raw = pick(s_lt, r_s, m_s);
      K_SMAX:  raw = pick(s_gt, r_s, m_s);
      K_UMIN:  raw = pick(u_lt, r_s, m_s);
      K_UMAX:  raw = pick(u_gt, r_s, m_s);
      K_CND:   raw = r_s;
      default: raw = '0;
    endcase
  end

  assign store_val = fit_s(raw, is_word);
  assign dest_val  = (kind == K_CND || kind == K_BAD) ? '0 : m_s;

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4:0]        op_code,
  input  logic [1:0]        width_sel,
  input  logic [XLEN-1:0]   mem_data,
  input  logic [XLEN-1:0]   reg_data,
  output logic              out_valid,
  output logic [XLEN-1:0]   store_data,
  output logic [XLEN-1:0]   dest_data,
  output logic              lr_flag,
  output logic              sc_flag,
  output logic              illegal
);

  localparam int PAD = XLEN - WORD_W;

  amo_kind_e       kind;
  logic            is_word, bad_req;
  logic [XLEN-1:0] store_nx, dest_nx;
  logic            word_q;

  amo_decode u_dec (
    .op_code   (op_code),
    .width_sel (width_sel),
    .kind      (kind),
    .is_word   (is_word),
    .bad_req   (bad_req)
  );

  amo_datapath #(.XLEN(XLEN), .WORD_W(WORD_W)) u_dp (
    .kind      (kind),
    .is_word   (is_word),
    .mem_val   (mem_data),
    .reg_val   (reg_data),
    .store_val (store_nx),
    .dest_val  (dest_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      store_data <= '0;
      dest_data  <= '0;
      lr_flag    <= 1'b0;
      sc_flag    <= 1'b0;
      illegal    <= 1'b0;
      word_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        store_data <= store_nx;
        dest_data  <= dest_nx;
        lr_flag    <= (kind == K_RSV);
        sc_flag    <= (kind == K_CND);
        illegal    <= bad_req;
        word_q     <= is_word;
      end
    end
  end

  // R11: the three flags never overlap
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lr_flag, sc_flag, illegal}));

  // R11: a rejected request leaves both data outputs at zero
  a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (store_data == '0 && dest_data == '0));

  // R7: word results returned to the destination are sign-extended
  a_r7_dest_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q && !illegal) |-> (dest_data[XLEN-1:WORD_W] == {PAD{dest_data[WORD_W-1]}}));

  // R8: word results written to memory are sign-extended
  a_r8_store_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q && !illegal) |-> (store_data[XLEN-1:WORD_W] == {PAD{store_data[WORD_W-1]}}));

  // R2: one cycle from request to result
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: outputs hold while no request arrives
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(store_data) && $stable(dest_data)
                   && $stable({lr_flag, sc_flag, illegal})));

endmodule

// File: tb/sim_amo_alu.sv
module sim_amo_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [1:0]  width_sel = 2'd3;
  logic [63:0] mem_data = '0;
  logic [63:0] reg_data = '0;
  logic        out_valid, lr_flag, sc_flag, illegal;
  logic [63:0] store_data, dest_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amo_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .width_sel(width_sel), .mem_data(mem_data), .reg_data(reg_data),
    .out_valid(out_valid), .store_data(store_data), .dest_data(dest_data),
    .lr_flag(lr_flag), .sc_flag(sc_flag), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference written with native integer types, per the requirements.
  function automatic void model(input logic [4:0] op, input logic [1:0] w,
                                input logic [63:0] m, input logic [63:0] r,
                                output logic [63:0] st, output logic [63:0] de,
                                output logic [2:0] fl);
    longint          sm, sr;
    longint unsigned um, ur;
    logic [63:0]     res;
    bit              word = (w == 2'd2);
    bit              ok_w = (w == 2'd2) || (w == 2'd3);
    if (word) begin
      sm = longint'(int'(m[31:0]));
      sr = longint'(int'(r[31:0]));
      um = longint'(m[31:0]);
      ur = longint'(r[31:0]);
    end else begin
      sm = m; sr = r; um = m; ur = r;
    end
    fl = 3'b000;  // {lr, sc, illegal}
    res = '0;
    case (op)
      5'h00: res = sm + sr;
      5'h01: res = sr;
      5'h04: res = sm ^ sr;
      5'h08: res = sm | sr;
      5'h0c: res = sm & sr;
      5'h10: res = (sr < sm) ? sr : sm;
      5'h14: res = (sr > sm) ? sr : sm;
      5'h18: res = (ur < um) ? sr : sm;
      5'h1c: res = (ur > um) ? sr : sm;
      5'h02: fl = 3'b100;
      5'h03: begin fl = 3'b010; res = sr; end
      default: fl = 3'b001;
    endcase
    if (!ok_w) begin fl = 3'b001; res = '0; end
    if (word) res = longint'(int'(res[31:0]));
    st = res;
    de = (fl[1] || fl[0]) ? 64'd0 : sm;
  endfunction

  task automatic run(input string tag, input logic [4:0] op, input logic [1:0] w,
                     input logic [63:0] m, input logic [63:0] r);
    logic [63:0] st, de;
    logic [2:0]  fl;
    model(op, w, m, r, st, de, fl);
    @(negedge clk);
    op_code = op; width_sel = w; mem_data = m; reg_data = r; in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " store"}, store_data, st);
    chk({tag, " dest"}, dest_data, de);
    chk({tag, " flags"}, {61'd0, lr_flag, sc_flag, illegal}, {61'd0, fl});
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 store", store_data, 64'd0);
    chk("R1 dest", dest_data, 64'd0);
    chk("R1 flags", {61'd0, lr_flag, sc_flag, illegal}, 64'd0);
  endtask

  task automatic t_add;
    run("R3 add dword wrap sign", 5'h00, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    chk("R3 add dword literal", store_data, 64'h8000_0000_0000_0000);
    run("R3 add dword wrap zero", 5'h00, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    chk("R3 add dword literal", store_data, 64'd1);
    run("R8 add word", 5'h00, 2'd2, 64'h1234_5678_7FFF_FFFF, 64'hABCD_0000_0000_0001);
    chk("R8 add word literal", store_data, 64'hFFFF_FFFF_8000_0000);
    chk("R7 add word dest literal", dest_data, 64'h0000_0000_7FFF_FFFF);
  endtask

  task automatic t_logic;
    run("R4 swap dword", 5'h01, 2'd3, 64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0BAD_F00D);
    chk("R4 swap literal", store_data, 64'hDEAD_BEEF_0BAD_F00D);
    run("R4 xor dword", 5'h04, 2'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);
    run("R4 or word", 5'h08, 2'd2, 64'hFFFF_FFFF_0000_00F0, 64'h0000_0000_8000_000F);
    run("R4 and word", 5'h0c, 2'd2, 64'h0000_0000_F00F_0000, 64'hFFFF_FFFF_FFFF_0000);
    run("R4 swap word", 5'h01, 2'd2, 64'h0, 64'hFFFF_FFFF_1234_5678);
    chk("R8 swap word literal", store_data, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_signed;
    run("R5 smin dword", 5'h10, 2'd3, 64'd3, -64'sd5);
    chk("R5 smin literal", store_data, -64'sd5);
    run("R5 smax dword", 5'h14, 2'd3, 64'd3, -64'sd5);
    chk("R5 smax literal", store_data, 64'd3);
    run("R5 smin equal", 5'h10, 2'd3, 64'd42, 64'd42);
    // upper halves claim the opposite sign of the low words
    run("R8 smin word upper ignored", 5'h10, 2'd2, 64'h8000_0000_0000_0010, 64'h7FFF_FFFF_FFFF_FFF0);
    chk("R5 smin word literal", store_data, 64'hFFFF_FFFF_FFFF_FFF0);
    run("R5 smax word", 5'h14, 2'd2, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001);
    chk("R5 smax word literal", store_data, 64'd1);
  endtask

  task automatic t_unsigned;
    run("R6 umin dword", 5'h18, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    chk("R6 umin literal", store_data, 64'd1);
    run("R6 umax dword", 5'h1c, 2'd3, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 umax literal", store_data, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R6 umax word", 5'h1c, 2'd2, 64'h0000_0001_7FFF_FFFF, 64'h0000_0000_8000_0000);
    chk("R6 umax word literal", store_data, 64'hFFFF_FFFF_8000_0000);
    run("R6 umin word", 5'h18, 2'd2, 64'h0000_0000_0000_0005, 64'h0000_0001_8000_0000);
    chk("R6 umin word literal", store_data, 64'd5);
  endtask

  task automatic t_dest;
    run("R7 dest word negative", 5'h04, 2'd2, 64'h0000_0000_9000_0001, 64'd0);
    chk("R7 dest literal", dest_data, 64'hFFFF_FFFF_9000_0001);
    run("R7 dest dword", 5'h08, 2'd3, 64'h8765_4321_0FED_CBA9, 64'd0);
    chk("R7 dest dword literal", dest_data, 64'h8765_4321_0FED_CBA9);
  endtask

  task automatic t_lrsc;
    run("R9 load-reserved word", 5'h02, 2'd2, 64'h5555_5555_8000_0003, 64'h1234);
    chk("R9 lr dest literal", dest_data, 64'hFFFF_FFFF_8000_0003);
    chk("R9 lr store literal", store_data, 64'd0);
    run("R10 store-conditional dword", 5'h03, 2'd3, 64'h9999, 64'hCAFE_F00D_1234_5678);
    chk("R10 sc store literal", store_data, 64'hCAFE_F00D_1234_5678);
    chk("R10 sc dest literal", dest_data, 64'd0);
    run("R10 store-conditional word", 5'h03, 2'd2, 64'h9999, 64'h0000_0000_F000_0000);
  endtask

  task automatic t_illegal;
    run("R11 code 05", 5'h05, 2'd3, 64'h1, 64'h2);
    run("R11 code 1f", 5'h1F, 2'd2, 64'h1, 64'h2);
    run("R11 width 0", 5'h00, 2'd0, 64'h1, 64'h2);
    run("R11 width 1 lr", 5'h02, 2'd1, 64'h1, 64'h2);
    chk("R11 illegal literal", {63'd0, illegal}, 64'd1);
  endtask

  task automatic t_hold;
    logic [63:0] st0, de0;
    run("R2 setup", 5'h00, 2'd3, 64'd100, 64'd23);
    st0 = store_data; de0 = dest_data;
    // in_valid is low; change every other input
    op_code = 5'h03; width_sel = 2'd0; mem_data = '1; reg_data = '1;
    @(negedge clk);
    chk("R2 no valid", {63'd0, out_valid}, 64'd0);
    chk("R2 store held", store_data, st0);
    chk("R2 dest held", dest_data, de0);
    chk("R2 flags held", {61'd0, lr_flag, sc_flag, illegal}, 64'd0);
    chk("R2 store value", st0, 64'd123);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_add;
    t_logic;
    t_signed;
    t_unsigned;
    t_dest;
    t_lrsc;
    t_illegal;
    t_hold;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule